// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short last-in, first-out record of how recent transmitted frames finished. The transmit MAC raises a one-cycle completion strobe for each frame, together with four flags: the frame asked for an interrupt on success, a jabber fault, a data underrun, and retries abandoned after the maximum number of collisions. Each accepted strobe pushes one entry. The host sees the newest entry as an 8-bit status byte. A host write to that status location arrives here as a pop strobe, which discards the newest entry and exposes the one below it.

The block also drives two further signals. The first is a transmit-complete interrupt cause that stays high while any stored entry is worth an interrupt. The second is a lock flag: after a jabber or underrun it tells the host that a transmit reset is required, and it holds the transmitter disabled until that reset arrives.

If a completion arrives while the stack is full, the new entry is dropped, and the entry currently on top is marked with an overflow bit. The depth is a parameter and defaults to 4. In the host's register map the byte lives at offset 0x0b of the operating register window. That decoding happens outside this block.

Top module: `txs_stack`

## Requirements
- R1: After reset, or while `rst_n` is low, `status_byte` is 0x00, `txc_cause` is 0, `reset_needed` is 0 and `tx_enable` is 1.
- R2: An accepted completion makes `status_byte` equal, from the next cycle:
  - bit 7 = 1;
  - bit 6 = interrupt request;
  - bit 5 = jabber;
  - bit 4 = underrun;
  - bit 3 = maximum collisions;
  - bit 2 = overflow, which is 0 for a new entry;
  - bits 1:0 = 0, always.
- R3: Entries come out newest first: after a pop, `status_byte` shows the entry pushed just before the popped one.
- R4: A cycle with `host_pop` high removes the top entry. A pop on an empty stack changes nothing.
- R5: With the stack empty, `status_byte` reads 0x00.
- R6: A completion that arrives while DEPTH entries are held, with no pop in the same cycle, is dropped. The top entry gains bit 2 = 1, and the entries below it are unchanged.
- R7: A pop and a completion in the same cycle replace the top entry with the new one, and the count is unchanged. This also holds when the stack is full, and no overflow is marked in that case.
- R8: `txc_cause` is 1 exactly when some stored entry has any of bits 6, 5, 4 or 3 set.
- R9: An accepted completion with jabber or underrun sets `reset_needed` to 1 and `tx_enable` to 0 from the next cycle. Both hold, through pops, until `tx_reset`.
- R10: `tx_reset` empties the stack and clears `reset_needed` from the next cycle. A completion in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | One-cycle frame-completion strobe from the MAC |
| cmp_irq_req | input | 1 | Frame requested an interrupt on success |
| cmp_jabber | input | 1 | Frame ended in a jabber fault |
| cmp_underrun | input | 1 | Frame ended in a data underrun |
| cmp_maxcoll | input | 1 | Frame abandoned after the maximum number of collisions |
| host_pop | input | 1 | Host write strobe to the status byte; pops the top entry |
| tx_reset | input | 1 | Transmit reset command |
| status_byte | output | 8 | Top entry, or 0x00 when empty |
| txc_cause | output | 1 | Transmit-complete interrupt cause |
| reset_needed | output | 1 | A transmit reset is required |
| tx_enable | output | 1 | Transmitter may run |

## Verification
The assertions take a few things for granted about the inputs:
- `cmp_valid` and `host_pop` are single-cycle strobes that are sampled only at rising edges.
- The four flags matter only while `cmp_valid` is high.
- `tx_reset` may coincide with any other strobe.

The stimulus changes every input only at falling edges and raises each strobe for exactly one cycle. It deliberately combines strobes: pop with completion, completion into a full stack, and reset with completion. This reaches the priority corners while staying inside those assumptions.

// File: rtl/txs_pkg.sv
package txs_pkg;

   // Stored flags of one completion entry
   typedef struct packed {
      logic irq;
      logic jab;
      logic und;
      logic mcol;
      logic ovf;
   } txs_entry_t;

   // Host-visible byte for an entry (bits 1:0 always zero)
   function automatic logic [7:0] txs_pack(input txs_entry_t e, input logic present);
      return present ? {1'b1, e.irq, e.jab, e.und, e.mcol, e.ovf, 2'b00} : 8'h00;
   endfunction

   // Entry is worth an interrupt
   function automatic logic txs_wants_irq(input txs_entry_t e);
      return e.irq | e.jab | e.und | e.mcol;
   endfunction

endpackage

// File: rtl/txs_lifo.sv
module txs_lifo
   import txs_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       push,
   input  txs_entry_t push_entry,
   input  logic       pop,
   output txs_entry_t top_entry,
   output logic       top_valid,
   output logic       any_cause
);

   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("txs_lifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          full, empty, pop_eff, drop;
   txs_entry_t    slot       [DEPTH];
   logic [DEPTH-1:0] slot_cause;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign pop_eff = pop && !empty;
   assign drop    = push && full && !pop_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (push && !pop_eff && !full) begin
         cnt <= cnt + CW'(1);
      end else if (pop_eff && !push) begin
         cnt <= cnt - CW'(1);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic wr_here;
      assign wr_here = push && !clear &&
                       ((pop_eff && cnt == CW'(i + 1)) || (!pop_eff && cnt == CW'(i)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot[i] <= '0;
         end else if (wr_here) begin
            slot[i] <= push_entry;
         end else if (drop && !clear && i == DEPTH - 1) begin
            slot[i].ovf <= 1'b1;
         end
      end

      assign slot_cause[i] = (CW'(i) < cnt) && txs_wants_irq(slot[i]);
   end

   always_comb begin
      top_entry = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (cnt == CW'(k + 1)) top_entry = slot[k];
      end
   end

   assign top_valid = !empty;
   assign any_cause = |slot_cause;

endmodule

// File: rtl/txs_lock.sv
module txs_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic set,
   output logic reset_needed,
   output logic tx_enable
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     reset_needed <= 1'b0;
      else if (clear) reset_needed <= 1'b0;
      else if (set)   reset_needed <= 1'b1;
   end

   assign tx_enable = !reset_needed;

endmodule

// File: rtl/txs_stack.sv
module txs_stack
   import txs_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmp_valid,
   input  logic       cmp_irq_req,
   input  logic       cmp_jabber,
   input  logic       cmp_underrun,
   input  logic       cmp_maxcoll,
   input  logic       host_pop,
   input  logic       tx_reset,
   output logic [7:0] status_byte,
   output logic       txc_cause,
   output logic       reset_needed,
   output logic       tx_enable
);

   logic       accept;
   txs_entry_t new_entry, top_entry;
   logic       top_valid;

   assign accept    = cmp_valid && !tx_reset;
   assign new_entry = '{irq: cmp_irq_req, jab: cmp_jabber, und: cmp_underrun,
                        mcol: cmp_maxcoll, ovf: 1'b0};

   txs_lifo #(.DEPTH(DEPTH)) u_lifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (tx_reset),
      .push       (accept),
      .push_entry (new_entry),
      .pop        (host_pop),
      .top_entry  (top_entry),
      .top_valid  (top_valid),
      .any_cause  (txc_cause)
   );

   txs_lock u_lock (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear        (tx_reset),
      .set          (accept && (cmp_jabber || cmp_underrun)),
      .reset_needed (reset_needed),
      .tx_enable    (tx_enable)
   );

   assign status_byte = txs_pack(top_entry, top_valid);

endmodule

// File: rtl/txs_stack_chk.sv
module txs_stack_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmp_valid,
   input logic       cmp_jabber,
   input logic       cmp_underrun,
   input logic       host_pop,
   input logic       tx_reset,
   input logic [7:0] status_byte,
   input logic       txc_cause,
   input logic       reset_needed
);

   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[1:0] == 2'b00);                                              // R2

   AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !tx_reset) |=> status_byte[7]);                              // R3

   AST_EMPTY_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !status_byte[7] |-> (!txc_cause && status_byte == 8'h00));                 // R8

   AST_EMPTY_POP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_byte[7] && !cmp_valid && host_pop) |=> !status_byte[7]);          // R4

   AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !tx_reset && (cmp_jabber || cmp_underrun)) |=> reset_needed); // R9

   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_needed && !tx_reset) |=> reset_needed);                             // R9

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_reset |=> (status_byte == 8'h00 && !txc_cause && !reset_needed));      // R10

endmodule

bind txs_stack txs_stack_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmp_valid    (cmp_valid),
   .cmp_jabber   (cmp_jabber),
   .cmp_underrun (cmp_underrun),
   .host_pop     (host_pop),
   .tx_reset     (tx_reset),
   .status_byte  (status_byte),
   .txc_cause    (txc_cause),
   .reset_needed (reset_needed)
);

// File: tb/txs_stack_test.sv
`timescale 1ns/1ps
module txs_stack_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_valid = 1'b0, cmp_irq_req = 1'b0, cmp_jabber = 1'b0;
   logic       cmp_underrun = 1'b0, cmp_maxcoll = 1'b0;
   logic       host_pop = 1'b0, tx_reset = 1'b0;
   logic [7:0] status_byte;
   logic       txc_cause, reset_needed, tx_enable;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   txs_stack #(.DEPTH(4)) uut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_irq_req(cmp_irq_req),
      .cmp_jabber(cmp_jabber), .cmp_underrun(cmp_underrun), .cmp_maxcoll(cmp_maxcoll),
      .host_pop(host_pop), .tx_reset(tx_reset), .status_byte(status_byte),
      .txc_cause(txc_cause), .reset_needed(reset_needed), .tx_enable(tx_enable)
   );

   // [16:10] = valid irq jab und mcol pop txrst, [9:2] = status, [1] = cause, [0] = reset_needed
   localparam int NV = 19;
   localparam logic [16:0] VEC [NV] = '{
      {7'b1100000, 8'hC0, 2'b10},   // R2 push irq
      {7'b1000100, 8'h88, 2'b10},   // R2 push maxcoll
      {7'b1000000, 8'h80, 2'b10},   // R8 plain on top, cause from below
      {7'b1000000, 8'h80, 2'b10},   // fill to depth 4
      {7'b1100000, 8'h84, 2'b10},   // R6 full: dropped, top marked
      {7'b0000010, 8'h80, 2'b10},   // R6 R3 pop: lower entry unmarked
      {7'b0000010, 8'h88, 2'b10},   // R3 pop
      {7'b1000010, 8'h80, 2'b10},   // R7 pop+push replaces top
      {7'b0000010, 8'hC0, 2'b10},   // R4 pop
      {7'b0000010, 8'h00, 2'b00},   // R5 empty
      {7'b0000010, 8'h00, 2'b00},   // R4 pop on empty
      {7'b1000000, 8'h80, 2'b00},   // R8 plain: no cause
      {7'b0000010, 8'h00, 2'b00},   // R5
      {7'b1001000, 8'h90, 2'b11},   // R9 underrun locks
      {7'b0000010, 8'h00, 2'b01},   // R9 lock survives pop
      {7'b1010001, 8'h00, 2'b00},   // R10 reset wins over completion
      {7'b1010000, 8'hA0, 2'b11},   // R9 jabber locks
      {7'b1000000, 8'h80, 2'b11},   // R8 cause from jabber below
      {7'b0000001, 8'h00, 2'b00}    // R10 reset empties and unlocks
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic [7:0] es, input logic ec, input logic er);
      chk({req, " status"}, status_byte, es);
      chk({req, " cause"}, {7'd0, txc_cause}, {7'd0, ec});
      chk({req, " reset_needed"}, {7'd0, reset_needed}, {7'd0, er});
      chk({req, " tx_enable"}, {7'd0, tx_enable}, {7'd0, ~er});
   endtask

   task automatic drive(input logic [6:0] c);
      {cmp_valid, cmp_irq_req, cmp_jabber, cmp_underrun, cmp_maxcoll, host_pop, tx_reset} = c;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_all("R1 in reset", 8'h00, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1 after reset", 8'h00, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][16:10]);
         @(posedge clk);
         #1;
         chk_all($sformatf("R2-table step %0d", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
      end

      // Directed: lock plus stored entry, then asynchronous reset (R1)
      @(negedge clk); drive(7'b1101000);
      @(negedge clk); drive(7'b0000000);
      chk_all("R9 irq+underrun", 8'hD0, 1'b1, 1'b1);
      #1 rst_n = 1'b0;
      #1 chk_all("R1 async reset", 8'h00, 1'b0, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      // Directed: full stack, pop and push together, no overflow (R7)
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); drive(7'b1000000);
      end
      @(negedge clk); drive(7'b1000110);
      @(negedge clk); drive(7'b0000000);
      chk_all("R7 full pop+push", 8'h88, 1'b1, 1'b0);
      @(negedge clk); drive(7'b0000010);
      @(negedge clk); drive(7'b0000000);
      chk_all("R6 no overflow mark below", 8'h80, 1'b0, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule